// File: doc/BRIEF.md
# Register-Mapped GPIO Controller with Single-Source Interrupt

This block is a general-purpose I/O controller for 22 pins, attached to a host through a simple register bus. Each write takes effect on the clock edge of its strobe, and each read returns data in the same cycle. Software sets each pin as an input or an output, sets the levels that the output pins drive, and reads back the synchronised level of every pin. Output pins are included in that readback.

Interrupts come from exactly one pin, and software chooses it. A configuration register holds a pin index and a trigger mode. The modes are off, active-low level, active-high level, and any-edge. In the level modes the interrupt line follows the watched pin's synchronised level directly. In edge mode a rise or a fall sets a sticky pending flag. The flag drives the interrupt line until software writes the configuration register again. The pads and the tristate cells sit outside the block, which supplies an output value and an output enable for each pin.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the direction, output-data and interrupt-configuration registers all read zero, every `pin_oe` bit is 0, `pin_out` is 0 and `irq` is low.
- R2: Byte offsets 0x00, 0x08, 0x10 and 0x18 select input data, output data, direction and interrupt configuration. Bit n of the first three belongs to pin n. In the configuration register, bits [5:0] hold the watched pin index and bits [7:6] hold the mode. Reads of any other offset, and of any unused bit, return zero. Writes to other offsets change nothing.
- R3: The input-data readback shows a change on `pin_in` after the second rising clock edge that samples the changed value, and not before. This holds whatever each pin's direction is.
- R4: `pin_oe[n]` equals direction bit n, where 1 means output and 0 means input.
- R5: `pin_out[n]` equals output-data bit n when direction bit n is 1, and is 0 otherwise.
- R6: Mode 0 keeps `irq` low whatever the pins do.
- R7: Mode 1 drives `irq` high exactly while the watched pin's synchronised level is 0. Mode 2 drives it high exactly while that level is 1.
- R8: In mode 3, any change of the watched pin's synchronised level, rising or falling, raises `irq` one cycle after the input-data readback shows the change. `irq` then stays high, whatever the pin does, until the configuration register is written.
- R9: A watched index above 21 never raises `irq`, in any mode.
- R10: A write to the configuration register clears the pending edge flag. The write wins over an edge detected in the same cycle.
- R11: Changes on pins other than the watched pin do not affect `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Write strobe; the write takes effect on this clock edge |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pin_in | input | 22 | Raw pin levels, asynchronous |
| pin_out | output | 22 | Level to drive on each pin |
| pin_oe | output | 22 | Output enable for each pin |
| irq | output | 1 | Interrupt to the host |

## Verification
The hardest case to reach is a configuration write that lands in the same cycle as the edge detector sees a change on the watched pin. The R10 priority is only visible in that one cycle. To get there, the stimulus toggles the watched pin and then issues the configuration write exactly two steps later, a count taken from the two synchroniser stages. A long random phase then mixes register writes, index choices that include out-of-range values, and pin changes. This phase meets further such coincidences, and a cycle-accurate behavioural model checks the outcome of each one.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [1:0] {
    TRIG_OFF  = 2'd0,
    TRIG_LOW  = 2'd1,
    TRIG_HIGH = 2'd2,
    TRIG_ANY  = 2'd3
  } trig_e;

  typedef struct packed {
    trig_e      mode;  // bits [7:6]
    logic [5:0] idx;   // bits [5:0]
  } irq_cfg_t;

  localparam int CFG_W = $bits(irq_cfg_t);

  localparam logic [4:0] OFS_DIN  = 5'h00;
  localparam logic [4:0] OFS_DOUT = 5'h08;
  localparam logic [4:0] OFS_DIR  = 5'h10;
  localparam logic [4:0] OFS_CFG  = 5'h18;

  // Interrupt level for a given mode, watched-pin validity, level and pending flag
  function automatic logic irq_from_mode(trig_e mode, logic idx_ok,
                                         logic lvl, logic pend);
    logic r;
    case (mode)
      TRIG_LOW:  r = idx_ok & ~lvl;
      TRIG_HIGH: r = idx_ok & lvl;
      TRIG_ANY:  r = pend;
      default:   r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 22,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_in,
  output logic [W-1:0] sync_lvl,
  output logic [W-1:0] prev_lvl
);
  logic [W-1:0] stage_q [STAGES+1];

  for (genvar s = 0; s <= STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= raw_in;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_lvl = stage_q[STAGES-1];
  assign prev_lvl = stage_q[STAGES];
endmodule

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
  import gpio_irq_pkg::*;
#(
  parameter int W      = 22,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [4:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [W-1:0]      sync_lvl,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      dout_q,
  output irq_cfg_t          cfg_q,
  output logic              cfg_wr
);
  localparam int PAD_W = DATA_W - W;
  localparam int CPAD_W = DATA_W - CFG_W;

  logic hit_din, hit_dout, hit_dir, hit_cfg, addr_hit;
  logic unused_wbits;

  assign hit_din  = (reg_addr == OFS_DIN);
  assign hit_dout = (reg_addr == OFS_DOUT);
  assign hit_dir  = (reg_addr == OFS_DIR);
  assign hit_cfg  = (reg_addr == OFS_CFG);
  assign addr_hit = hit_din | hit_dout | hit_dir | hit_cfg;
  assign cfg_wr   = reg_wr & hit_cfg;
  assign unused_wbits = ^reg_wdata[DATA_W-1:W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      dout_q <= '0;
      cfg_q  <= '0;
    end else if (reg_wr) begin
      if (hit_dout) dout_q <= reg_wdata[W-1:0];
      if (hit_dir)  dir_q  <= reg_wdata[W-1:0];
      if (hit_cfg)  cfg_q  <= irq_cfg_t'(reg_wdata[CFG_W-1:0]);
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (hit_din)  reg_rdata = {{PAD_W{1'b0}}, sync_lvl};
    if (hit_dout) reg_rdata = {{PAD_W{1'b0}}, dout_q};
    if (hit_dir)  reg_rdata = {{PAD_W{1'b0}}, dir_q};
    if (hit_cfg)  reg_rdata = {{CPAD_W{1'b0}}, cfg_q};
  end

  // R2
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_hit |-> reg_rdata == '0);

  // R2
  dir_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && hit_dir) |=> dir_q == $past(reg_wdata[W-1:0]));
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int W = 22
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sync_lvl,
  input  logic [W-1:0] prev_lvl,
  input  irq_cfg_t     cfg,
  input  logic         cfg_wr,
  output logic         irq
);
  logic idx_ok, sel_now, sel_prev, sel_change, edge_pend;

  always_comb begin
    idx_ok   = 1'b0;
    sel_now  = 1'b0;
    sel_prev = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (cfg.idx == 6'(i)) begin
        idx_ok   = 1'b1;
        sel_now  = sync_lvl[i];
        sel_prev = prev_lvl[i];
      end
    end
  end

  assign sel_change = idx_ok & (sel_now ^ sel_prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) edge_pend <= 1'b0;
    else if (cfg_wr) edge_pend <= 1'b0;
    else if (cfg.mode == TRIG_ANY && sel_change) edge_pend <= 1'b1;
  end

  assign irq = irq_from_mode(cfg.mode, idx_ok, sel_now, edge_pend);

  // R6
  mode_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.mode == TRIG_OFF |-> !irq);

  // R9
  bad_index_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_ok |-> !irq);

  // R10
  cfg_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !edge_pend);

  // R8
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_pend && !cfg_wr) |=> edge_pend);

  // R8
  pend_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(edge_pend) |-> $past(sel_change));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 22,
  parameter int DATA_W   = 32,
  parameter int SYNC_STG = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [4:0]          reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq
);
  logic [NUM_PINS-1:0] sync_lvl, prev_lvl, dir_q, dout_q;
  irq_cfg_t cfg_q;
  logic cfg_wr;

  gpio_in_sync #(.W(NUM_PINS), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_in(pin_in),
    .sync_lvl(sync_lvl), .prev_lvl(prev_lvl)
  );

  gpio_reg_bank #(.W(NUM_PINS), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .sync_lvl(sync_lvl), .reg_rdata(reg_rdata),
    .dir_q(dir_q), .dout_q(dout_q), .cfg_q(cfg_q), .cfg_wr(cfg_wr)
  );

  gpio_irq_unit #(.W(NUM_PINS)) u_irq (
    .clk(clk), .rst_n(rst_n), .sync_lvl(sync_lvl), .prev_lvl(prev_lvl),
    .cfg(cfg_q), .cfg_wr(cfg_wr), .irq(irq)
  );

  assign pin_oe  = dir_q;
  assign pin_out = dout_q & dir_q;

  // R5
  input_pins_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);
endmodule

// File: tb/test_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module test_gpio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [21:0] pin_in = '0;
  logic [21:0] pin_out, pin_oe;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_irq_ctrl i_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // Behavioural model: history of pin samples, newest first
  logic [21:0] hist[$];
  logic [21:0] m_dout, m_dir;
  logic [7:0]  m_cfg;
  bit          m_pend;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit lvl_at(int age, int ix);
    if (ix > 21) return 1'b0;
    return hist[age][ix];
  endfunction

  function automatic logic [31:0] exp_rdata(logic [4:0] a);
    case (a)
      5'h00: return {10'd0, hist[1]};
      5'h08: return {10'd0, m_dout};
      5'h10: return {10'd0, m_dir};
      5'h18: return {24'd0, m_cfg};
      default: return 32'd0;
    endcase
  endfunction

  function automatic bit exp_irq();
    int ix = int'(m_cfg[5:0]);
    bit ok = (ix <= 21);
    case (m_cfg[7:6])
      2'd1: return ok && !lvl_at(1, ix);
      2'd2: return ok && lvl_at(1, ix);
      2'd3: return m_pend;
      default: return 1'b0;
    endcase
  endfunction

  task automatic model_edge(bit wr, logic [4:0] a, logic [31:0] wd, logic [21:0] pins);
    int ix = int'(m_cfg[5:0]);
    bit chg = (ix <= 21) && (lvl_at(1, ix) != lvl_at(2, ix));
    if (wr && a == 5'h18) m_pend = 0;
    else if (m_cfg[7:6] == 2'd3 && chg) m_pend = 1;
    if (wr) begin
      if (a == 5'h08) m_dout = wd[21:0];
      if (a == 5'h10) m_dir  = wd[21:0];
      if (a == 5'h18) m_cfg  = wd[7:0];
    end
    hist.push_front(pins);
    if (hist.size() > 4) void'(hist.pop_back());
  endtask

  // One clock: drive at negedge, model at posedge, compare at next negedge
  task automatic step(bit wr, logic [4:0] a, logic [31:0] wd, logic [21:0] pins, string itag);
    reg_wr = wr; reg_addr = a; reg_wdata = wd; pin_in = pins;
    @(posedge clk);
    model_edge(wr, a, wd, pins);
    @(negedge clk);
    reg_wr = 1'b0;
    check("R2", reg_rdata, exp_rdata(a));
    check("R4", {10'd0, pin_oe}, {10'd0, m_dir});
    check("R5", {10'd0, pin_out}, {10'd0, m_dout & m_dir});
    check(itag, {31'd0, irq}, {31'd0, exp_irq()});
  endtask

  task automatic wr_cfg(int ix, int mode, logic [21:0] pins, string tag);
    step(1, 5'h18, {24'd0, 2'(mode), 6'(ix)}, pins, tag);
  endtask

  initial begin
    logic [21:0] p;
    p = '0;
    m_dout = '0; m_dir = '0; m_cfg = '0; m_pend = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    reg_addr = 5'h10; #1;
    check("R1", reg_rdata, 32'd0);
    reg_addr = 5'h08; #1;
    check("R1", reg_rdata, 32'd0);
    reg_addr = 5'h18; #1;
    check("R1", reg_rdata, 32'd0);
    check("R1", {10'd0, pin_oe}, 32'd0);
    check("R1", {10'd0, pin_out}, 32'd0);
    check("R1", {31'd0, irq}, 32'd0);
    rst_n = 1'b1;
    hist = {22'd0, 22'd0, 22'd0};

    // R2 / R4 / R5: direction and output data
    step(1, 5'h10, 32'hFFFF_F0F0, p, "R6");
    step(0, 5'h10, 32'h0, p, "R6");
    check("R2", reg_rdata, 32'h003F_F0F0);
    step(1, 5'h08, 32'h0015_5AA5, p, "R6");
    check("R5", {10'd0, pin_out}, 32'h0015_50A0);
    check("R4", {10'd0, pin_oe}, 32'h003F_F0F0);
    step(1, 5'h04, 32'hFFFF_FFFF, p, "R6");
    check("R2", reg_rdata, 32'd0);
    step(0, 5'h10, 32'h0, p, "R6");
    check("R2", reg_rdata, 32'h003F_F0F0);

    // R3: two-edge synchroniser latency, output pins included
    p = 22'h2A_AAAA;
    step(0, 5'h00, 32'h0, p, "R6");
    check("R3", reg_rdata, 32'd0);
    step(0, 5'h00, 32'h0, p, "R6");
    check("R3", reg_rdata, 32'h002A_AAAA);
    for (int i = 0; i < 40; i++) begin
      p = 22'($urandom);
      step(0, 5'(($urandom % 4) * 8), 32'h0, p, "R3");
    end

    // R7 high level on pin 7, R11 other pins ignored
    p = '0;
    wr_cfg(7, 2, p, "R7");
    step(0, 5'h00, 0, p, "R7");
    p[7] = 1'b1;
    step(0, 5'h00, 0, p, "R7");
    step(0, 5'h00, 0, p, "R7");
    check("R7", {31'd0, irq}, 32'd1);
    p[8] = 1'b1; p[6] = 1'b1;
    step(0, 5'h00, 0, p, "R11");
    step(0, 5'h00, 0, p, "R11");
    check("R11", {31'd0, irq}, 32'd1);
    p[7] = 1'b0;
    step(0, 5'h00, 0, p, "R7");
    step(0, 5'h00, 0, p, "R7");
    check("R7", {31'd0, irq}, 32'd0);
    // R7 low level
    wr_cfg(7, 1, p, "R7");
    check("R7", {31'd0, irq}, 32'd1);
    // R6 off mode
    wr_cfg(7, 0, p, "R6");
    for (int i = 0; i < 6; i++) begin
      p[7] = ~p[7];
      step(0, 5'h00, 0, p, "R6");
      check("R6", {31'd0, irq}, 32'd0);
    end

    // R8 edge mode: rise, sticky, clear, fall
    p = '0;
    step(0, 5'h00, 0, p, "R8");
    step(0, 5'h00, 0, p, "R8");
    wr_cfg(7, 3, p, "R8");
    p[7] = 1'b1;
    step(0, 5'h00, 0, p, "R8");
    step(0, 5'h00, 0, p, "R8");
    check("R8", {31'd0, irq}, 32'd0);
    step(0, 5'h00, 0, p, "R8");
    check("R8", {31'd0, irq}, 32'd1);
    p[7] = 1'b0;
    for (int i = 0; i < 5; i++) step(0, 5'h00, 0, p, "R8");
    check("R8", {31'd0, irq}, 32'd1);
    wr_cfg(7, 3, p, "R10");
    check("R10", {31'd0, irq}, 32'd0);
    p[7] = 1'b1;
    step(0, 5'h00, 0, p, "R8");
    p[7] = 1'b0;
    step(0, 5'h00, 0, p, "R8");
    step(0, 5'h00, 0, p, "R8");
    check("R8", {31'd0, irq}, 32'd1);
    wr_cfg(7, 3, p, "R10");
    step(0, 5'h00, 0, p, "R8");
    step(0, 5'h00, 0, p, "R8");
    // R10 write in the same cycle as a detected change
    p[7] = 1'b1;
    step(0, 5'h00, 0, p, "R10");
    step(0, 5'h00, 0, p, "R10");
    wr_cfg(7, 3, p, "R10");
    check("R10", {31'd0, irq}, 32'd0);
    for (int i = 0; i < 4; i++) step(0, 5'h00, 0, p, "R10");
    check("R10", {31'd0, irq}, 32'd0);
    // R11 unselected pins in edge mode
    for (int i = 0; i < 8; i++) begin
      p[3] = ~p[3]; p[21] = ~p[21];
      step(0, 5'h00, 0, p, "R11");
    end
    check("R11", {31'd0, irq}, 32'd0);

    // R9 out-of-range indices; pin 21 is the last valid one
    p = 22'h3F_FFFF;
    wr_cfg(21, 2, p, "R7");
    step(0, 5'h00, 0, p, "R7");
    step(0, 5'h00, 0, p, "R7");
    check("R7", {31'd0, irq}, 32'd1);
    wr_cfg(22, 2, p, "R9");
    check("R9", {31'd0, irq}, 32'd0);
    wr_cfg(40, 2, p, "R9");
    p = '0;
    step(0, 5'h00, 0, p, "R9");
    wr_cfg(63, 1, p, "R9");
    step(0, 5'h00, 0, p, "R9");
    check("R9", {31'd0, irq}, 32'd0);
    wr_cfg(40, 3, p, "R9");
    for (int i = 0; i < 6; i++) begin
      p = ~p;
      step(0, 5'h00, 0, p, "R9");
      check("R9", {31'd0, irq}, 32'd0);
    end

    // Random mix against the model
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom % 16);
      if ($urandom % 4 == 0) p = p ^ (22'd1 << ($urandom % 22));
      if (r == 0) step(1, 5'h18, {24'd0, 2'($urandom), 6'($urandom % 32)}, p, "R8");
      else if (r == 1) step(1, 5'h10, $urandom, p, "R4");
      else if (r == 2) step(1, 5'h08, $urandom, p, "R5");
      else if (r == 3) step(1, 5'($urandom), $urandom, p, "R2");
      else step(0, 5'($urandom), 0, p, "R7");
    end

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule